// File: doc/BRIEF.md
# Dual-Channel SAR Converter Conversion Controller

This block sits on the host side of a two-channel simultaneous-sampling SAR converter. It owns the active-low conversion-start line and watches the converter's busy line. When a conversion finishes, it reads both 14-bit channel results in parallel over a serial link made of chip-select, serial clock and two data inputs. Each result pair is delivered with a one-cycle valid strobe.

Each request picks one of two power policies. In normal mode the controller raises the start line while the converter is still busy, so the converter stays powered. In shutdown mode it keeps the line low through the end of the conversion, so the converter powers down after it. The controller still reads the results, and then parks. On the next request it raises the line and holds it high for the wake-up window. Only then does it start another conversion. The same wake-up hold is applied after reset, whatever state the converter powered up in. The window is set in system clocks as clock rate (MHz) × wake time (µs).

Top module: `dual_sar_ctrl`

## Requirements
- R1: During reset and after it, the conversion-start line is high and chip-select is high. `ready` stays low for at least `CLK_MHZ*WAKE_US` clocks after reset is released, and `resultValid` stays low.
- R2: A conversion begins only with a falling edge of `cnvStart`. That edge occurs only in the cycle after one in which `ready` was high.
- R3: In normal mode (`shutdownSel`=0 at the request), `cnvStart` is high before busy falls, so the converter stays powered. `ready` returns high once the read is complete.
- R4: In shutdown mode (`shutdownSel`=1), `cnvStart` is low when busy falls and stays low, with `ready` low, until the next request. Before the next falling edge, the line rises and is held high for at least `CLK_MHZ*WAKE_US` clocks.
- R5: A read lowers `csN` and issues exactly `RES_BITS` falling edges of `sclk`, which idles high whenever `csN` is high. Both data inputs are sampled on each falling edge of `sclk`, MSB first. The converter is expected to change its data output after each rising edge.
- R6: `resultValid` is a one-cycle pulse in the cycle in which `csN` returns high. `resultA`/`resultB` then hold the words shifted in from `sdoA`/`sdoB`.
- R7: A request that arrives while a conversion, read or wake-up is in progress is kept and serviced on return to idle. Several such requests merge into one conversion, which uses the mode of the latest request.
- R8: `ready` is high exactly while the converter is awake and the controller is idle.
- R9: Results of a shutdown-mode conversion are read correctly although the converter has already powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle conversion request |
| shutdownSel | input | 1 | Mode for the request: 1 powers the converter down after it |
| busyIn | input | 1 | Converter busy line (asynchronous) |
| sdoA | input | 1 | Serial data, channel A |
| sdoB | input | 1 | Serial data, channel B |
| cnvStart | output | 1 | Conversion-start line, active falling edge |
| csN | output | 1 | Serial chip-select, active low |
| sclk | output | 1 | Serial clock, idles high |
| resultA | output | RES_BITS | Channel A result |
| resultB | output | RES_BITS | Channel B result |
| resultValid | output | 1 | One-cycle strobe for a new result pair |
| ready | output | 1 | Converter awake and controller idle |

## Verification
The assertions assume that busy rises within a few clocks of a falling `cnvStart` edge. They also assume it then stays high for longer than the two-flop synchronizer delay, so the raw busy fall can be judged against the line level. They further assume `SCLK_HALF` is at least 2. The bench converter model raises busy one clock after it sees the falling edge and keeps it high for twelve clocks. It changes its data bits only one clock after seeing chip-select fall or `sclk` rise. The model also flags any conversion started too early after power-down, or while still busy.

// File: rtl/dual_sar_pkg.sv
package dual_sar_pkg;

  typedef enum logic [2:0] {
    ST_WAKE,
    ST_IDLE,
    ST_CONV_START,
    ST_CONV_BUSY,
    ST_READ,
    ST_SLEEP
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic readGo;    // begin a serial frame
    logic wakeHold;  // keep the wake-up timer cleared
  } dpCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic readDone;  // frame finished last cycle
    logic wakeDone;  // wake-up window elapsed
    logic busySync;  // synchronized busy level
  } dpStat_t;

endpackage

// File: rtl/dual_sar_fsm.sv
module dual_sar_fsm
  import dual_sar_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    shutdownSel,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    cnvStart,
  output logic    ready
);

  ctrlState_e state, nextState;
  logic modeReg;
  logic pendReg, pendMode;
  logic reqAny, reqMode, launch;

  assign reqAny  = startReq | pendReg;
  assign reqMode = startReq ? shutdownSel : pendMode;
  assign launch  = (state == ST_IDLE) && reqAny;

  always_comb begin
    nextState = state;
    case (state)
      ST_WAKE:       if (stat.wakeDone) nextState = ST_IDLE;
      ST_IDLE:       if (reqAny) nextState = ST_CONV_START;
      ST_CONV_START: if (stat.busySync) nextState = ST_CONV_BUSY;
      ST_CONV_BUSY:  if (!stat.busySync) nextState = ST_READ;
      ST_READ:       if (stat.readDone) nextState = modeReg ? ST_SLEEP : ST_IDLE;
      ST_SLEEP:      if (reqAny) nextState = ST_WAKE;
      default:       nextState = ST_WAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_WAKE;
      modeReg  <= 1'b0;
      pendReg  <= 1'b0;
      pendMode <= 1'b0;
    end else begin
      state <= nextState;
      if (launch) begin
        modeReg <= reqMode;
        pendReg <= 1'b0;
      end else if (startReq) begin
        pendReg  <= 1'b1;
        pendMode <= shutdownSel;
      end
    end
  end

  always_comb begin
    case (state)
      ST_WAKE, ST_IDLE:       cnvStart = 1'b1;
      ST_CONV_START:          cnvStart = 1'b0;
      ST_CONV_BUSY, ST_READ:  cnvStart = ~modeReg;
      ST_SLEEP:               cnvStart = 1'b0;
      default:                cnvStart = 1'b1;
    endcase
  end

  assign ready        = (state == ST_IDLE);
  assign cmd.readGo   = (state == ST_CONV_BUSY) && !stat.busySync;
  assign cmd.wakeHold = (state != ST_WAKE);

endmodule

// File: rtl/dual_sar_dp.sv
module dual_sar_dp
  import dual_sar_pkg::*;
#(
  parameter int RES_BITS  = 14,
  parameter int SCLK_HALF = 4,
  parameter int WAKE_CYC  = 17500
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  output dpStat_t             stat,
  input  logic                busyIn,
  input  logic                sdoA,
  input  logic                sdoB,
  output logic                csN,
  output logic                sclk,
  output logic [RES_BITS-1:0] resultA,
  output logic [RES_BITS-1:0] resultB,
  output logic                resultValid
);

  localparam int HALF_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BIT_W  = $clog2(RES_BITS);
  localparam int WAKE_W = $clog2(WAKE_CYC + 1);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(SCLK_HALF - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(RES_BITS - 1);
  localparam logic [WAKE_W-1:0] WAKE_END  = WAKE_W'(WAKE_CYC);

  // busy synchronizer
  logic [1:0] busyMeta;
  always_ff @(posedge clk) begin
    if (!rstN) busyMeta <= 2'b00;
    else       busyMeta <= {busyMeta[0], busyIn};
  end

  // wake-up timer
  logic [WAKE_W-1:0] wakeCnt;
  always_ff @(posedge clk) begin
    if (!rstN || cmd.wakeHold) wakeCnt <= '0;
    else if (wakeCnt != WAKE_END) wakeCnt <= wakeCnt + WAKE_W'(1);
  end

  // serial frame engine
  logic              active, phaseLow;
  logic [HALF_W-1:0] halfCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              csNReg, sclkReg, doneReg, validReg;
  logic              halfEnd, sampleEn, frameEnd;

  assign halfEnd  = active && !cmd.readGo && (halfCnt == HALF_LAST);
  assign sampleEn = halfEnd && !phaseLow;
  assign frameEnd = halfEnd && phaseLow && (bitCnt == BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      phaseLow <= 1'b0;
      halfCnt  <= '0;
      bitCnt   <= '0;
      csNReg   <= 1'b1;
      sclkReg  <= 1'b1;
      doneReg  <= 1'b0;
      validReg <= 1'b0;
    end else begin
      doneReg  <= 1'b0;
      validReg <= 1'b0;
      if (cmd.readGo) begin
        active   <= 1'b1;
        csNReg   <= 1'b0;
        sclkReg  <= 1'b1;
        halfCnt  <= '0;
        phaseLow <= 1'b0;
        bitCnt   <= '0;
      end else if (active) begin
        if (halfCnt == HALF_LAST) begin
          halfCnt <= '0;
          if (!phaseLow) begin
            sclkReg  <= 1'b0;
            phaseLow <= 1'b1;
          end else begin
            sclkReg  <= 1'b1;
            phaseLow <= 1'b0;
            if (bitCnt == BIT_LAST) begin
              active   <= 1'b0;
              csNReg   <= 1'b1;
              doneReg  <= 1'b1;
              validReg <= 1'b1;
            end else begin
              bitCnt <= bitCnt + BIT_W'(1);
            end
          end
        end else begin
          halfCnt <= halfCnt + HALF_W'(1);
        end
      end
    end
  end

  // one shift and result register pair per channel
  logic [1:0] sdoVec;
  assign sdoVec = {sdoB, sdoA};

  for (genvar ch = 0; ch < 2; ch++) begin : gen_ch
    logic [RES_BITS-1:0] shiftReg;
    logic [RES_BITS-1:0] resReg;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shiftReg <= '0;
        resReg   <= '0;
      end else begin
        if (sampleEn) shiftReg <= {shiftReg[RES_BITS-2:0], sdoVec[ch]};
        if (frameEnd) resReg <= shiftReg;
      end
    end
  end

  assign resultA       = gen_ch[0].resReg;
  assign resultB       = gen_ch[1].resReg;
  assign resultValid   = validReg;
  assign csN           = csNReg;
  assign sclk          = sclkReg;
  assign stat.readDone = doneReg;
  assign stat.wakeDone = (wakeCnt == WAKE_END);
  assign stat.busySync = busyMeta[1];

endmodule

// File: rtl/dual_sar_ctrl.sv
module dual_sar_ctrl
  import dual_sar_pkg::*;
#(
  parameter int CLK_MHZ   = 250,
  parameter int WAKE_US   = 70,
  parameter int RES_BITS  = 14,
  parameter int SCLK_HALF = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                shutdownSel,
  input  logic                busyIn,
  input  logic                sdoA,
  input  logic                sdoB,
  output logic                cnvStart,
  output logic                csN,
  output logic                sclk,
  output logic [RES_BITS-1:0] resultA,
  output logic [RES_BITS-1:0] resultB,
  output logic                resultValid,
  output logic                ready
);

  localparam int WAKE_CYC = CLK_MHZ * WAKE_US;

  dpCmd_t  cmd;
  dpStat_t stat;

  dual_sar_fsm fsm_i (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .shutdownSel (shutdownSel),
    .stat        (stat),
    .cmd         (cmd),
    .cnvStart    (cnvStart),
    .ready       (ready)
  );

  dual_sar_dp #(
    .RES_BITS  (RES_BITS),
    .SCLK_HALF (SCLK_HALF),
    .WAKE_CYC  (WAKE_CYC)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .stat        (stat),
    .busyIn      (busyIn),
    .sdoA        (sdoA),
    .sdoB        (sdoB),
    .csN         (csN),
    .sclk        (sclk),
    .resultA     (resultA),
    .resultB     (resultB),
    .resultValid (resultValid)
  );

endmodule

// File: rtl/dual_sar_chk.sv
module dual_sar_chk #(
  parameter int RES_BITS = 14,
  parameter int WAKE_CYC = 17500
) (
  input logic clk,
  input logic rstN,
  input logic busyIn,
  input logic cnvStart,
  input logic csN,
  input logic sclk,
  input logic resultValid,
  input logic ready
);

  localparam int HW = $clog2(WAKE_CYC + 1);
  localparam int FW = $clog2(RES_BITS + 1) + 1;

  logic [HW-1:0] highCnt;
  logic [FW-1:0] fallCnt;
  logic sleepFlag, prevBusy, prevCnv, prevCs, prevSclk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highCnt   <= '0;
      fallCnt   <= '0;
      sleepFlag <= 1'b1;
      prevBusy  <= 1'b0;
      prevCnv   <= 1'b1;
      prevCs    <= 1'b1;
      prevSclk  <= 1'b1;
    end else begin
      prevBusy <= busyIn;
      prevCnv  <= cnvStart;
      prevCs   <= csN;
      prevSclk <= sclk;
      if (!cnvStart) highCnt <= '0;
      else if (highCnt != HW'(WAKE_CYC)) highCnt <= highCnt + HW'(1);
      if (prevBusy && !busyIn && !cnvStart) sleepFlag <= 1'b1;
      else if (prevCnv && !cnvStart) sleepFlag <= 1'b0;
      if (prevCs && !csN) fallCnt <= '0;
      else if (prevSclk && !sclk) fallCnt <= fallCnt + FW'(1);
    end
  end

  // R1 R4
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cnvStart) && sleepFlag) |-> (highCnt >= HW'(WAKE_CYC)));

  // R2
  start_from_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cnvStart) |-> $past(ready));

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  // R5
  bit_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (fallCnt == FW'(RES_BITS)));

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R6
  valid_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $rose(csN));

  // R8
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (cnvStart && csN && !resultValid));

endmodule

bind dual_sar_ctrl dual_sar_chk #(
  .RES_BITS (RES_BITS),
  .WAKE_CYC (CLK_MHZ * WAKE_US)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .busyIn      (busyIn),
  .cnvStart    (cnvStart),
  .csN         (csN),
  .sclk        (sclk),
  .resultValid (resultValid),
  .ready       (ready)
);

// File: tb/dual_sar_ctrl_tb_top.sv
module dual_sar_ctrl_tb_top;

  localparam int RES      = 14;
  localparam int HALF     = 2;
  localparam int MHZ      = 1;
  localparam int WUS      = 70;
  localparam int WCYC     = MHZ * WUS;
  localparam int CONV_LEN = 12;

  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0, shutdownSel = 1'b0;
  logic busyIn = 1'b0, sdoA = 1'b0, sdoB = 1'b0;
  logic cnvStart, csN, sclk, resultValid, ready;
  logic [RES-1:0] resultA, resultB;

  always #2 clk = ~clk;

  dual_sar_ctrl #(
    .CLK_MHZ (MHZ), .WAKE_US (WUS), .RES_BITS (RES), .SCLK_HALF (HALF)
  ) dut_i (
    .clk (clk), .rstN (rstN), .startReq (startReq), .shutdownSel (shutdownSel),
    .busyIn (busyIn), .sdoA (sdoA), .sdoB (sdoB), .cnvStart (cnvStart),
    .csN (csN), .sclk (sclk), .resultA (resultA), .resultB (resultB),
    .resultValid (resultValid), .ready (ready)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  function automatic logic [RES-1:0] codeOf(int n, int ch);
    case (n % 4)
      0:       return (ch == 0) ? 14'h3FFF : 14'h0000;
      1:       return (ch == 0) ? 14'h1555 : 14'h2AAA;
      default: return 14'((n * 1237 + ch * 811 + 5) & 16'h3FFF);
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // converter model
  int busyCnt = 0, wakeCnt = 0, violations = 0, convIdx = 0, bitIdx = 0;
  bit needWake = 1'b1, modelAsleep = 1'b0;
  logic prevCnv = 1'b1, prevCs = 1'b1, prevSclk = 1'b1;
  logic [RES-1:0] curA = '0, curB = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= 0; wakeCnt <= 0; needWake <= 1'b1; busyIn <= 1'b0;
      prevCnv <= 1'b1; prevCs <= 1'b1; prevSclk <= 1'b1;
    end else begin
      prevCnv  <= cnvStart;
      prevCs   <= csN;
      prevSclk <= sclk;
      if (cnvStart) wakeCnt <= (wakeCnt < 100000) ? wakeCnt + 1 : wakeCnt;
      else          wakeCnt <= 0;
      if (prevCnv && !cnvStart) begin
        if (needWake && wakeCnt < WCYC) violations <= violations + 1;
        if (busyIn) violations <= violations + 1;
        needWake    <= 1'b0;
        modelAsleep <= 1'b0;
        busyIn      <= 1'b1;
        busyCnt     <= CONV_LEN;
        curA        <= codeOf(convIdx, 0);
        curB        <= codeOf(convIdx, 1);
        convIdx     <= convIdx + 1;
      end else if (busyIn) begin
        if (busyCnt == 1) begin
          busyIn <= 1'b0;
          if (!cnvStart) begin
            needWake    <= 1'b1;
            modelAsleep <= 1'b1;
          end
        end
        busyCnt <= busyCnt - 1;
      end
      if (prevCs && !csN) begin
        sdoA   <= curA[RES-1];
        sdoB   <= curB[RES-1];
        bitIdx <= RES - 1;
      end else if (!csN && !prevSclk && sclk) begin
        if (bitIdx > 0) begin
          sdoA <= curA[bitIdx-1];
          sdoB <= curB[bitIdx-1];
        end
        bitIdx <= bitIdx - 1;
      end
    end
  end

  // frame and strobe monitors
  int frames = 0, frameBad = 0, falls = 0, validBad = 0, validCount = 0;
  logic mPrevSclk = 1'b1, mPrevCs = 1'b1, mPrevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (!csN && mPrevSclk && !sclk) falls++;
      if (csN && !sclk) frameBad++;
      if (!mPrevCs && csN) begin
        frames++;
        if (falls != RES) frameBad++;
        falls = 0;
      end
      if (resultValid) begin
        validCount++;
        if (mPrevValid || !(csN && !mPrevCs)) validBad++;
      end
    end
    mPrevSclk  = sclk;
    mPrevCs    = csN;
    mPrevValid = resultValid;
  end

  int expIdx = 0;

  task automatic waitValid(string req);
    int t = 0;
    while (!resultValid && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(resultValid, req, "valid timeout", 0, 1);
    chk(resultA == codeOf(expIdx, 0), req, "resultA", int'(resultA), int'(codeOf(expIdx, 0)));
    chk(resultB == codeOf(expIdx, 1), req, "resultB", int'(resultB), int'(codeOf(expIdx, 1)));
    expIdx++;
    @(negedge clk);
  endtask

  task automatic pulseReq(bit mode);
    @(negedge clk);
    startReq    = 1'b1;
    shutdownSel = mode;
    @(negedge clk);
    startReq    = 1'b0;
    shutdownSel = 1'b0;
  endtask

  task automatic checkAfter(bit mode);
    if (mode) begin
      chk(modelAsleep == 1'b1, "R4", "converter asleep", int'(modelAsleep), 1);
      repeat (30) @(negedge clk);
      chk(ready == 1'b0, "R4", "ready while asleep", int'(ready), 0);
      chk(cnvStart == 1'b0, "R4", "line low while asleep", int'(cnvStart), 0);
    end else begin
      chk(modelAsleep == 1'b0, "R3", "converter awake", int'(modelAsleep), 0);
      repeat (3) @(negedge clk);
      chk(ready == 1'b1, "R3", "ready after read", int'(ready), 1);
    end
  endtask

  initial begin
    int cyc;
    repeat (5) @(negedge clk);
    chk(cnvStart == 1'b1, "R1", "line in reset", int'(cnvStart), 1);
    chk(csN == 1'b1, "R1", "csN in reset", int'(csN), 1);
    chk(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
    chk(resultValid == 1'b0, "R1", "valid in reset", int'(resultValid), 0);
    rstN = 1'b1;
    cyc = 0;
    while (!ready && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (!ready) chk(cnvStart == 1'b1, "R1", "line held during wake", int'(cnvStart), 1);
    end
    chk(cyc >= WCYC, "R1", "cycles to ready", cyc, WCYC);
    repeat (10) @(negedge clk);
    chk(ready == 1'b1, "R8", "ready while idle", int'(ready), 1);

    // sweep over modes and code patterns
    for (int i = 0; i < 20; i++) begin
      bit mode = ((i % 3) == 2) || ((i % 5) == 0);
      pulseReq(mode);
      waitValid(mode ? "R9" : "R6");
      checkAfter(mode);
    end

    // R7: request during a read is held; mode of the pending request used
    pulseReq(1'b0);
    while (csN) @(negedge clk);
    pulseReq(1'b1);
    waitValid("R7");
    waitValid("R7");
    checkAfter(1'b1);

    // R7: requests during wake-up merge; latest mode wins
    pulseReq(1'b0);
    repeat (10) @(negedge clk);
    chk(ready == 1'b0, "R8", "ready during wake", int'(ready), 0);
    pulseReq(1'b1);
    cyc = validCount;
    waitValid("R7");
    repeat (400) @(negedge clk);
    chk(validCount == cyc + 1, "R7", "merged request count", validCount - cyc, 1);
    chk(modelAsleep == 1'b1, "R7", "latest mode applied", int'(modelAsleep), 1);

    // wake from sleep into normal mode
    pulseReq(1'b0);
    waitValid("R4");
    checkAfter(1'b0);

    chk(violations == 0, "R2", "converter timing violations", violations, 0);
    chk(frameBad == 0, "R5", "bad frames", frameBad, 0);
    chk(frames == expIdx, "R5", "frame count", frames, expIdx);
    chk(validBad == 0, "R6", "bad valid strobes", validBad, 0);
    chk(validCount == expIdx, "R6", "valid count", validCount, expIdx);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run incomplete actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule